// File: doc/BRIEF.md
# Dual-Mode Watchdog and Interval Timer

This block is a register-programmed up-counter that serves one of two roles. In watchdog role, software must reload the counter before it wraps. A wrap with the reset permission bit set produces a system reset request lasting a fixed number of clocks, and the block returns itself to its reset state. In interval role, every wrap raises a sticky overflow flag that can drive an interrupt request. Software clears the flag with a read-then-write handshake.

The count rate comes from two free-running divider chains that are held at zero while the timer is stopped. A source bit picks the chain, and a 3-bit code picks one of eight power-of-two taps on it. The shift for a tap is `BASE + code*STEP`, with its own base and step for each chain. The role bit and the clock selection can only change while the timer is stopped. Writes to them while it runs are dropped.

All access goes through a small synchronous register port. Reads are combinational on the address. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. A read counts as a read at the edge where `bus_sel` is high and `bus_wr` is low.

Top module: `guard_timer`

## Requirements
- R1: After `rst` every register reads 0, and `sys_rst_req` and `tick_irq` are 0. The address map is: 0 = control, 1 = counter (value in the low `CNT_W` bits), 2 = clock select (bit 3 = chain, bits 2:0 = tap code). Address 3 reads 0 and ignores writes.
- R2: Control register bit 5 is the run bit. While it is 1, the counter increments once every 2^s clocks. The shift s is `BASE_A+code*STEP_A` for chain 0 and `BASE_B+code*STEP_B` for chain 1. The first increment comes 2^s clocks after the edge that sets the run bit. While the run bit is 0 the counter holds its value.
- R3: The counter wraps from all ones to 0. In interval role (control bit 6 = 0), each wrap sets the overflow flag, which is control bit 7.
- R4: `tick_irq` is high exactly when the overflow flag and the interrupt enable (control bit 3) are both 1.
- R5: In watchdog role (control bit 6 = 1) with the reset permission bit (control bit 4) at 1, a wrap drives `sys_rst_req` high for exactly `RST_LEN` cycles. This starts on the cycle after the wrap edge. At that same edge, control, clock select and counter return to 0.
- R6: In watchdog role with control bit 4 at 0, a wrap gives no reset request, does not set the overflow flag, and the counter keeps running.
- R7: While the run bit is 1, writes to the clock select register and to control bit 6 are ignored. The other control bits can be written at any time.
- R8: A counter write loads the value at any time. When it coincides with a counter increment, the load wins and that wrap is not produced.
- R9: A read of the control register that returns the overflow flag as 1 arms a clear permission. A control write with bit 7 at 0 clears the flag only while that permission is armed. Writing 1 to bit 7 never sets the flag.
- R10: Any write, to any address, disarms the clear permission.
- R11: When a wrap sets the flag on the same edge as an armed clearing write, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| sys_rst_req | output | 1 | Watchdog reset request pulse |
| tick_irq | output | 1 | Interval interrupt request |

## Verification
The bench builds the block with a 4-bit counter, with chain 0 at base 0 and step 1, chain 1 at base 1 and step 2, and a 5-cycle reset pulse. This makes a full wrap at every chain-0 tap and at the first four chain-1 taps short enough to time exactly, from two start values each. It also makes watchdog wraps, reloads and the clear collision land on chosen cycles, because the expected wrap edge is simply 2^s times the remaining count.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;

   localparam int ADDR_W   = 2;
   localparam int CODE_W   = 3;
   localparam int NUM_TAPS = 1 << CODE_W;
   localparam int NUM_CHN  = 2;

   // control register field positions
   localparam int OVF_BIT   = 7;
   localparam int MODE_BIT  = 6;
   localparam int RUN_BIT   = 5;
   localparam int RSTEN_BIT = 4;
   localparam int IRQEN_BIT = 3;

   // clock select field position
   localparam int SRC_BIT = 3;

   typedef enum logic [ADDR_W-1:0] {
      REG_CTRL  = 2'd0,
      REG_COUNT = 2'd1,
      REG_CLK   = 2'd2,
      REG_NONE  = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic wd_mode;
      logic run;
      logic rst_en;
      logic irq_en;
   } ctrl_t;

   typedef struct packed {
      logic              src;
      logic [CODE_W-1:0] code;
   } clkcfg_t;

endpackage

// File: rtl/guard_prescaler.sv
module guard_prescaler
   import guard_timer_pkg::*;
#(
   parameter int PRE_W  = 20,
   parameter int BASE_A = 1,
   parameter int STEP_A = 1,
   parameter int BASE_B = 5,
   parameter int STEP_B = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              run,
   input  logic              src,
   input  logic [CODE_W-1:0] code,
   output logic              tick
);

   logic [NUM_CHN-1:0] chain_tick;

   for (genvar g = 0; g < NUM_CHN; g++) begin : g_chain
      localparam int BASE = (g == 0) ? BASE_A : BASE_B;
      localparam int STEP = (g == 0) ? STEP_A : STEP_B;

      logic [PRE_W-1:0]    div_q;
      logic [NUM_TAPS-1:0] hit;

      always_ff @(posedge clk) begin
         if (rst || !run) div_q <= '0;
         else             div_q <= div_q + 1'b1;
      end

      for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
         localparam int SH = BASE + t * STEP;
         localparam logic [PRE_W-1:0] MASK = PRE_W'((64'd1 << SH) - 64'd1);
         assign hit[t] = ((div_q & MASK) == MASK);
      end

      assign chain_tick[g] = hit[code];
   end

   assign tick = run && chain_tick[src];

endmodule

// File: rtl/guard_counter.sv
module guard_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic             ovf_evt
);

   logic at_max;

   assign at_max  = &cnt_q;
   assign ovf_evt = tick && at_max && !load;

   always_ff @(posedge clk) begin
      if (rst || clr)  cnt_q <= '0;
      else if (load)   cnt_q <= load_val;
      else if (tick)   cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/guard_regs.sv
module guard_regs
   import guard_timer_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr,
   input  logic              wr_ctrl,
   input  logic              wr_clk,
   input  logic              rd_ctrl,
   input  logic              any_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ovf_set,
   output ctrl_t             ctrl_q,
   output clkcfg_t           cfg_q,
   output logic              ovf_q,
   output logic              armed_q
);

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q.run     <= wdata[RUN_BIT];
         ctrl_q.rst_en  <= wdata[RSTEN_BIT];
         ctrl_q.irq_en  <= wdata[IRQEN_BIT];
         ctrl_q.wd_mode <= ctrl_q.run ? ctrl_q.wd_mode : wdata[MODE_BIT];
      end
   end

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         cfg_q <= '0;
      end else if (wr_clk && !ctrl_q.run) begin
         cfg_q.src  <= wdata[SRC_BIT];
         cfg_q.code <= wdata[CODE_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (rst || clr)                                 ovf_q <= 1'b0;
      else if (ovf_set)                               ovf_q <= 1'b1;
      else if (wr_ctrl && !wdata[OVF_BIT] && armed_q) ovf_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst || clr)            armed_q <= 1'b0;
      else if (any_wr)           armed_q <= 1'b0;
      else if (rd_ctrl && ovf_q) armed_q <= 1'b1;
   end

endmodule

// File: rtl/guard_rst_pulse.sv
module guard_rst_pulse #(
   parameter int RST_LEN = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic fire,
   output logic pulse
);

   localparam int LEN_W = $clog2(RST_LEN + 1);

   logic [LEN_W-1:0] left_q;

   always_ff @(posedge clk) begin
      if (rst)               left_q <= '0;
      else if (fire)         left_q <= LEN_W'(RST_LEN);
      else if (left_q != '0) left_q <= left_q - 1'b1;
   end

   assign pulse = (left_q != '0);

endmodule

// File: rtl/guard_timer.sv
module guard_timer
   import guard_timer_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int DATA_W  = 8,
   parameter int BASE_A  = 1,
   parameter int STEP_A  = 1,
   parameter int BASE_B  = 5,
   parameter int STEP_B  = 2,
   parameter int RST_LEN = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              sys_rst_req,
   output logic              tick_irq
);

   localparam int TOP_A  = BASE_A + (NUM_TAPS - 1) * STEP_A;
   localparam int TOP_B  = BASE_B + (NUM_TAPS - 1) * STEP_B;
   localparam int MAX_SH = (TOP_A > TOP_B) ? TOP_A : TOP_B;
   localparam int PRE_W  = (MAX_SH < 1) ? 1 : MAX_SH;

   if (DATA_W < 8) begin : g_bad_data
      $error("guard_timer: DATA_W must be at least 8");
   end
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("guard_timer: CNT_W must lie in 2..DATA_W");
   end
   if (RST_LEN < 1) begin : g_bad_len
      $error("guard_timer: RST_LEN must be at least 1");
   end
   if (BASE_A < 0 || BASE_B < 0 || STEP_A < 1 || STEP_B < 1) begin : g_bad_tap
      $error("guard_timer: tap bases must be >= 0 and steps >= 1");
   end
   if (MAX_SH > 30) begin : g_bad_shift
      $error("guard_timer: largest prescaler shift exceeds 30");
   end

   logic             wr_any, rd_any, wr_ctrl, wr_cnt, wr_clk, rd_ctrl;
   ctrl_t            ctrl_q;
   clkcfg_t          cfg_q;
   logic             ovf_q, armed_q;
   logic             tick_w, ovf_evt_w, fire_w, ovf_set_w;
   logic [CNT_W-1:0] cnt_q;

   assign wr_any  = bus_sel && bus_wr;
   assign rd_any  = bus_sel && !bus_wr;
   assign wr_ctrl = wr_any && (bus_addr == REG_CTRL);
   assign wr_cnt  = wr_any && (bus_addr == REG_COUNT);
   assign wr_clk  = wr_any && (bus_addr == REG_CLK);
   assign rd_ctrl = rd_any && (bus_addr == REG_CTRL);

   assign fire_w    = ovf_evt_w && ctrl_q.wd_mode && ctrl_q.rst_en;
   assign ovf_set_w = ovf_evt_w && !ctrl_q.wd_mode;

   guard_prescaler #(
      .PRE_W (PRE_W),
      .BASE_A(BASE_A),
      .STEP_A(STEP_A),
      .BASE_B(BASE_B),
      .STEP_B(STEP_B)
   ) u_pre (
      .clk (clk),
      .rst (rst),
      .run (ctrl_q.run),
      .src (cfg_q.src),
      .code(cfg_q.code),
      .tick(tick_w)
   );

   guard_counter #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .clr     (fire_w),
      .tick    (tick_w),
      .load    (wr_cnt),
      .load_val(bus_wdata[CNT_W-1:0]),
      .cnt_q   (cnt_q),
      .ovf_evt (ovf_evt_w)
   );

   guard_regs #(
      .DATA_W(DATA_W)
   ) u_regs (
      .clk    (clk),
      .rst    (rst),
      .clr    (fire_w),
      .wr_ctrl(wr_ctrl),
      .wr_clk (wr_clk),
      .rd_ctrl(rd_ctrl),
      .any_wr (wr_any),
      .wdata  (bus_wdata),
      .ovf_set(ovf_set_w),
      .ctrl_q (ctrl_q),
      .cfg_q  (cfg_q),
      .ovf_q  (ovf_q),
      .armed_q(armed_q)
   );

   guard_rst_pulse #(
      .RST_LEN(RST_LEN)
   ) u_pulse (
      .clk  (clk),
      .rst  (rst),
      .fire (fire_w),
      .pulse(sys_rst_req)
   );

   always_comb begin
      bus_rdata = '0;
      case (reg_sel_e'(bus_addr))
         REG_CTRL: begin
            bus_rdata[OVF_BIT]   = ovf_q;
            bus_rdata[MODE_BIT]  = ctrl_q.wd_mode;
            bus_rdata[RUN_BIT]   = ctrl_q.run;
            bus_rdata[RSTEN_BIT] = ctrl_q.rst_en;
            bus_rdata[IRQEN_BIT] = ctrl_q.irq_en;
         end
         REG_COUNT: bus_rdata[CNT_W-1:0] = cnt_q;
         REG_CLK: begin
            bus_rdata[SRC_BIT]      = cfg_q.src;
            bus_rdata[CODE_W-1:0]   = cfg_q.code;
         end
         default: bus_rdata = '0;
      endcase
   end

   assign tick_irq = ovf_q && ctrl_q.irq_en;

endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk #(
   parameter int CNT_W   = 8,
   parameter int RST_LEN = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             wd_rst,
   input logic             ovf_evt,
   input logic             wd_mode,
   input logic             rst_en,
   input logic             run,
   input logic             fire,
   input logic             ovf_q,
   input logic             armed,
   input logic             ctrl_wr,
   input logic             wdata_ovf,
   input logic [3:0]       cfg,
   input logic [CNT_W-1:0] cnt
);

   localparam int HW = $clog2(RST_LEN + 2);

   logic [HW-1:0] hi_cnt;

   always_ff @(posedge clk) begin
      if (rst)         hi_cnt <= '0;
      else if (wd_rst) hi_cnt <= hi_cnt + 1'b1;
      else             hi_cnt <= '0;
   end

   // R5: pulse never runs past its length
   p_pulse_max_r5: assert property (@(posedge clk) disable iff (rst)
      wd_rst |-> (hi_cnt < HW'(RST_LEN)));

   // R5: pulse ends only after its full length
   p_pulse_len_r5: assert property (@(posedge clk) disable iff (rst)
      $fell(wd_rst) |-> (hi_cnt == HW'(RST_LEN)));

   // R6: a request only follows a permitted watchdog wrap
   p_rst_cause_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(wd_rst) |-> $past(ovf_evt && wd_mode && rst_en));

   // R3: wrap leaves the counter at zero
   p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
      ovf_evt |=> (cnt == '0));

   // R7: clock selection frozen while running
   p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (rst)
      (run && !fire) |=> $stable(cfg));

   // R9: flag falls only through an armed clear or a watchdog reset
   p_clear_armed_r9: assert property (@(posedge clk) disable iff (rst)
      $fell(ovf_q) |-> $past(armed && ctrl_wr && !wdata_ovf) || $past(fire));

   // R11: a setting wrap always leaves the flag at 1
   p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
      (ovf_evt && !wd_mode) |=> ovf_q);

endmodule

bind guard_timer guard_timer_chk #(
   .CNT_W  (CNT_W),
   .RST_LEN(RST_LEN)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .wd_rst   (sys_rst_req),
   .ovf_evt  (ovf_evt_w),
   .wd_mode  (ctrl_q.wd_mode),
   .rst_en   (ctrl_q.rst_en),
   .run      (ctrl_q.run),
   .fire     (fire_w),
   .ovf_q    (ovf_q),
   .armed    (armed_q),
   .ctrl_wr  (wr_ctrl),
   .wdata_ovf(bus_wdata[guard_timer_pkg::OVF_BIT]),
   .cfg      ({cfg_q.src, cfg_q.code}),
   .cnt      (cnt_q)
);

// File: tb/guard_timer_bench.sv
module guard_timer_bench;

   localparam int W  = 4;
   localparam int BA = 0;
   localparam int SA = 1;
   localparam int BB = 1;
   localparam int SB = 2;
   localparam int RL = 5;

   localparam int F_OVF = 8'h80;
   localparam int F_WD  = 8'h40;
   localparam int F_RUN = 8'h20;
   localparam int F_RSE = 8'h10;
   localparam int F_IRQ = 8'h08;

   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_CNT  = 2'd1;
   localparam logic [1:0] A_CLK  = 2'd2;
   localparam logic [1:0] A_NONE = 2'd3;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       sys_rst_req;
   logic       tick_irq;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;

   guard_timer #(
      .CNT_W(W), .DATA_W(8), .BASE_A(BA), .STEP_A(SA),
      .BASE_B(BB), .STEP_B(SB), .RST_LEN(RL)
   ) u_guard_timer (
      .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sys_rst_req(sys_rst_req), .tick_irq(tick_irq)
   );

   always #5 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000 && !done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog (all requirements): actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic peek(input logic [1:0] a, output int v);
      bus_addr = a;
      #1;
      v = int'(bus_rdata);
   endtask

   task automatic check_reg(input string tag, input logic [1:0] a, input int exp);
      int v;
      peek(a, v);
      check(tag, v, exp);
   endtask

   task automatic wr(input logic [1:0] a, input int d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = 8'(d);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      v = int'(bus_rdata);
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0;
      idle(3);
      rst = 1'b0;
   endtask

   initial begin
      int v;
      do_reset();

      // R1: reset state and address map
      check_reg("R1 ctrl after reset", A_CTRL, 0);
      check_reg("R1 count after reset", A_CNT, 0);
      check_reg("R1 clksel after reset", A_CLK, 0);
      check_reg("R1 unused address", A_NONE, 0);
      check("R1 irq after reset", tick_irq, 0);
      check("R1 reset req after reset", sys_rst_req, 0);

      // R2 R3 R4: period sweep over chains, taps and start values
      for (int src = 0; src < 2; src++) begin
         for (int code = 0; code < (src != 0 ? 4 : 8); code++) begin
            for (int k = 0; k < 2; k++) begin
               int c0, s, n;
               c0 = (k != 0) ? 13 : 0;
               s  = (src != 0) ? (BB + code * SB) : (BA + code * SA);
               n  = (1 << s) * ((1 << W) - c0);
               do_reset();
               wr(A_CLK, src * 8 + code);
               wr(A_CNT, c0);
               wr(A_CTRL, F_RUN | F_IRQ);
               idle(n - 1);
               check_reg("R2 count one step before wrap", A_CNT, (1 << W) - 1);
               check_reg("R3 flag clear before wrap", A_CTRL, F_RUN | F_IRQ);
               check("R4 irq low before wrap", tick_irq, 0);
               idle(1);
               check_reg("R3 flag set at wrap", A_CTRL, F_OVF | F_RUN | F_IRQ);
               check_reg("R3 count wraps to zero", A_CNT, 0);
               check("R4 irq high after wrap", tick_irq, 1);
            end
         end
      end

      // R4 R9: irq gating and clear handshake
      do_reset();
      wr(A_CNT, 15);
      wr(A_CTRL, F_RUN);
      idle(1);
      check_reg("R3 flag after one-step wrap", A_CTRL, F_OVF | F_RUN);
      check("R4 irq masked", tick_irq, 0);
      wr(A_CTRL, F_RUN | F_IRQ);
      check_reg("R9 unarmed zero write keeps flag", A_CTRL, F_OVF | F_RUN | F_IRQ);
      check("R4 irq when enabled", tick_irq, 1);
      wr(A_CTRL, 0);
      check_reg("R9 stop keeps flag", A_CTRL, F_OVF);
      rd(A_CTRL, v);
      check("R9 read returns flag", v, F_OVF);
      wr(A_CTRL, 0);
      check_reg("R9 armed zero write clears", A_CTRL, 0);
      wr(A_CTRL, F_OVF);
      check_reg("R9 writing one does not set", A_CTRL, 0);

      // R10 R8 R2 R12
      wr(A_CNT, 15);
      wr(A_CTRL, F_RUN);
      wr(A_CTRL, 0);
      check_reg("R3 flag set on stopping edge", A_CTRL, F_OVF);
      check_reg("R3 count wrapped", A_CNT, 0);
      rd(A_CTRL, v);
      wr(A_CNT, 5);
      wr(A_CTRL, 0);
      check_reg("R10 count write disarms", A_CTRL, F_OVF);
      check_reg("R8 load while stopped", A_CNT, 5);
      idle(20);
      check_reg("R2 stopped counter holds", A_CNT, 5);
      wr(A_NONE, 8'hFF);
      check_reg("R12 unused write leaves ctrl", A_CTRL, F_OVF);
      check_reg("R12 unused write leaves count", A_CNT, 5);
      check_reg("R12 unused write leaves clksel", A_CLK, 0);
      check_reg("R12 unused address reads zero", A_NONE, 0);

      // R11: set beats armed clear on the same edge
      wr(A_CNT, 12);
      wr(A_CTRL, F_RUN);
      rd(A_CTRL, v);
      check("R9 read while running", v, F_OVF | F_RUN);
      idle(2);
      wr(A_CTRL, F_RUN);
      check_reg("R11 set wins over clear", A_CTRL, F_OVF | F_RUN);
      wr(A_CTRL, 0);
      check_reg("R10 colliding write disarmed", A_CTRL, F_OVF);

      // R7: frozen fields while running
      do_reset();
      wr(A_CLK, 2);
      wr(A_CTRL, F_RUN);
      wr(A_CLK, 8'h0F);
      check_reg("R7 clksel frozen", A_CLK, 2);
      wr(A_CTRL, F_RUN | F_WD);
      check_reg("R7 mode frozen", A_CTRL, F_RUN);
      wr(A_CTRL, F_WD);
      check_reg("R7 stop with mode ignored", A_CTRL, 0);
      wr(A_CLK, 8'h0B);
      check_reg("R7 clksel when stopped", A_CLK, 8'h0B);
      wr(A_CTRL, F_WD);
      check_reg("R7 mode when stopped", A_CTRL, F_WD);

      // R8: load beats tick and suppresses the wrap
      do_reset();
      wr(A_CNT, 13);
      wr(A_CTRL, F_RUN);
      idle(2);
      wr(A_CNT, 9);
      check_reg("R8 load wins over tick", A_CNT, 9);
      check_reg("R8 no wrap on load edge", A_CTRL, F_RUN);
      idle(1);
      check_reg("R2 counting resumes", A_CNT, 10);

      // R5: watchdog reset pulse
      do_reset();
      wr(A_CLK, 1);
      wr(A_CNT, 12);
      wr(A_CTRL, F_RUN | F_WD | F_RSE | F_IRQ);
      idle(7);
      check("R5 no request before wrap", sys_rst_req, 0);
      check_reg("R5 count before wrap", A_CNT, 15);
      idle(1);
      check("R5 request starts", sys_rst_req, 1);
      check_reg("R5 ctrl cleared", A_CTRL, 0);
      check_reg("R5 count cleared", A_CNT, 0);
      check_reg("R5 clksel cleared", A_CLK, 0);
      for (int k = 1; k < RL; k++) begin
         idle(1);
         check("R5 request held", sys_rst_req, 1);
      end
      idle(1);
      check("R5 request ends", sys_rst_req, 0);

      // R5 R8: serviced watchdog never fires
      do_reset();
      wr(A_CNT, 10);
      wr(A_CTRL, F_RUN | F_WD | F_RSE);
      for (int k = 0; k < 20; k++) begin
         idle(3);
         wr(A_CNT, 10);
         check("R8 reload keeps watchdog quiet", sys_rst_req, 0);
      end
      check_reg("R5 serviced ctrl intact", A_CTRL, F_RUN | F_WD | F_RSE);

      // R6: watchdog without reset permission
      do_reset();
      wr(A_CNT, 14);
      wr(A_CTRL, F_RUN | F_WD);
      idle(2);
      check_reg("R6 count wrapped", A_CNT, 0);
      check_reg("R6 no flag, still running", A_CTRL, F_RUN | F_WD);
      for (int k = 0; k < 16; k++) begin
         idle(1);
         check("R6 no request", sys_rst_req, 0);
      end
      check_reg("R6 second wrap", A_CNT, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule